// File: doc/BRIEF.md
# Banked Memory-Map Chip-Select Decoder

This block turns the 16-bit external address of a small microcontroller into active-low chip selects for three regions. The lower half of the map goes to a 32 KB RAM. Most of the upper half goes to a flash window. The final 2 KB is split into eight 256-byte peripheral windows. The selects are built from address bits alone, so they are already settled when any read, write or fetch strobe goes low.

The data-read strobe and the code-fetch strobe are merged into one active-low read strobe. As a result, a code fetch and a data read both reach the same writable memory. A 4-bit bank register, loaded like an output port, drives the flash address lines above A14. This lets software switch between up to sixteen banks of the 30 KB flash window.

Top module: `bankedSelectDecoder`

## Requirements
- R1: With `addrValid` high and address bit 15 at 0 (0x0000–0x7FFF), `ramSelN` is 0. Otherwise it is 1.
- R2: With `addrValid` high, bit 15 at 1 and at least one of bits 14..11 at 0 (0x8000–0xF7FF), `flashSelN` is 0. Otherwise it is 1.
- R3: With `addrValid` high and bits 15..11 all 1 (0xF800–0xFFFF), exactly bit k of `periphSelN` is 0, where k = address bits 10..8. Each of the eight windows covers 256 consecutive addresses.
- R4: At most one of the ten select lines is 0 for any input. While `addrValid` is 0, all selects are 1.
- R5: `rdMergedN` is 0 when `rdN` or `fetchN` is 0, and 1 only when both are 1.
- R6: The selects depend on the address and `addrValid` only. Changing `rdN`, `wrN` or `fetchN` at a fixed address leaves every select unchanged.
- R7: After reset the bank register is 0, so `flashHiAddr` reads 0.
- R8: When `bankWe` is 1 at a rising clock edge, `bankWData` is loaded. `flashHiAddr` (flash A18..A15, bit 0 = A15) shows the loaded value from that edge on.
- R9: Without `bankWe`, the bank register holds its value whatever the address or the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Latched external address |
| addrValid | input | 1 | Address is valid; when low all selects are released |
| rdN | input | 1 | Active-low data read strobe |
| wrN | input | 1 | Active-low data write strobe |
| fetchN | input | 1 | Active-low code fetch strobe |
| bankWe | input | 1 | Bank register write enable |
| bankWData | input | 4 | Value loaded into the bank register |
| ramSelN | output | 1 | Active-low RAM select |
| flashSelN | output | 1 | Active-low flash select |
| periphSelN | output | 8 | Active-low peripheral window selects |
| rdMergedN | output | 1 | Combined active-low read strobe |
| flashHiAddr | output | 4 | Upper flash address lines from the bank register |

## Verification
The bench uses the default parameters: 16 address bits, 256-byte pages, three peripheral index bits and a four-bit bank. With these values the whole map of 65536 addresses can be swept one address per clock. Every region edge (0x7FFF/0x8000, 0xF7FF/0xF800) and every peripheral index is reached, and the bench confirms each index is hit 256 times. Bank writes during the sweep step through all sixteen bank values. The strobe inputs follow address-derived patterns, which covers the merged read strobe and the rule that selects do not depend on the strobes.

// File: rtl/bankDecPkg.sv
package bankDecPkg;
  typedef struct packed {
    logic ramHit;
    logic flashHit;
    logic periphHit;
    logic bankLoad;
  } regionStrobesT;
endpackage

// File: rtl/decodeCtl.sv
module decodeCtl
  import bankDecPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 8,
  parameter int PERIPH_IDX_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrValid,
  input  logic              bankWe,
  output regionStrobesT     strobes
);
  localparam int TOP_BIT = ADDR_W - 1;
  localparam int WIN_LO  = PAGE_W + PERIPH_IDX_W;

  logic topWindow;

  // High when every bit between the peripheral index and the top bit is set
  assign topWindow = &addr[TOP_BIT-1:WIN_LO];

  always_comb begin
    strobes.ramHit    = addrValid & ~addr[TOP_BIT];
    strobes.flashHit  = addrValid &  addr[TOP_BIT] & ~topWindow;
    strobes.periphHit = addrValid &  addr[TOP_BIT] &  topWindow;
    strobes.bankLoad  = bankWe;
  end
endmodule

// File: rtl/decodeDatapath.sv
module decodeDatapath
  import bankDecPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 8,
  parameter int PERIPH_IDX_W = 3,
  parameter int BANK_W       = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           addr,
  input  regionStrobesT               strobes,
  input  logic [BANK_W-1:0]           bankWData,
  input  logic                        rdN,
  input  logic                        fetchN,
  output logic                        ramSelN,
  output logic                        flashSelN,
  output logic [(1<<PERIPH_IDX_W)-1:0] periphSelN,
  output logic                        rdMergedN,
  output logic [BANK_W-1:0]           flashHiAddr
);
  localparam int N_PERIPH = 1 << PERIPH_IDX_W;

  logic [BANK_W-1:0]       bankQ;
  logic [PERIPH_IDX_W-1:0] periphIdx;

  assign periphIdx = addr[PAGE_W +: PERIPH_IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bankQ <= '0;
    else if (strobes.bankLoad) bankQ <= bankWData;
  end

  assign flashHiAddr = bankQ;
  assign ramSelN     = ~strobes.ramHit;
  assign flashSelN   = ~strobes.flashHit;
  // Active-low AND: either strobe low pulls the merged read low
  assign rdMergedN   = rdN & fetchN;

  for (genvar g = 0; g < N_PERIPH; g++) begin : gPeriph
    assign periphSelN[g] = ~(strobes.periphHit && (periphIdx == PERIPH_IDX_W'(g)));
  end

  AST_PERIPH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.periphHit |-> ($countones(~periphSelN) == 1 && !periphSelN[periphIdx])); // R3
  AST_PERIPH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.periphHit |-> (&periphSelN)); // R3
  AST_FETCH_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchN || !rdN) |-> !rdMergedN); // R5
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bankLoad |=> (flashHiAddr == $past(bankWData))); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bankLoad |=> $stable(flashHiAddr)); // R9
  AST_BANK_RESET: assert property (@(posedge clk)
    !rstN |-> (bankQ == '0)); // R7
endmodule

// File: rtl/bankedSelectDecoder.sv
module bankedSelectDecoder
  import bankDecPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 8,
  parameter int PERIPH_IDX_W = 3,
  parameter int BANK_W       = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          addrValid,
  input  logic                          rdN,
  input  logic                          wrN,
  input  logic                          fetchN,
  input  logic                          bankWe,
  input  logic [BANK_W-1:0]             bankWData,
  output logic                          ramSelN,
  output logic                          flashSelN,
  output logic [(1<<PERIPH_IDX_W)-1:0]  periphSelN,
  output logic                          rdMergedN,
  output logic [BANK_W-1:0]             flashHiAddr
);
  localparam int TOP_BIT = ADDR_W - 1;
  localparam int WIN_LO  = PAGE_W + PERIPH_IDX_W;

  regionStrobesT strobes;

  decodeCtl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PERIPH_IDX_W(PERIPH_IDX_W)
  ) i_ctl (
    .addr(addr), .addrValid(addrValid), .bankWe(bankWe), .strobes(strobes)
  );

  decodeDatapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PERIPH_IDX_W(PERIPH_IDX_W), .BANK_W(BANK_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .strobes(strobes),
    .bankWData(bankWData), .rdN(rdN), .fetchN(fetchN),
    .ramSelN(ramSelN), .flashSelN(flashSelN), .periphSelN(periphSelN),
    .rdMergedN(rdMergedN), .flashHiAddr(flashHiAddr)
  );

  AST_RAM_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addr[TOP_BIT]) |-> !ramSelN); // R1
  AST_FLASH_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addr[TOP_BIT] && !(&addr[TOP_BIT-1:WIN_LO])) |-> !flashSelN); // R2
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~ramSelN, ~flashSelN, ~periphSelN}) <= 1); // R4
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> (ramSelN && flashSelN && (&periphSelN))); // R4
  AST_WR_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(addr) && $stable(addrValid)) |-> ($stable(ramSelN) && $stable(flashSelN) && $stable(periphSelN))); // R6
endmodule

// File: tb/test_bankedSelectDecoder.sv
module test_bankedSelectDecoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] addr;
  logic        addrValid, rdN, wrN, fetchN, bankWe;
  logic [3:0]  bankWData;
  logic        ramSelN, flashSelN, rdMergedN;
  logic [7:0]  periphSelN;
  logic [3:0]  flashHiAddr;

  int   checks = 0;
  int   fails  = 0;
  int   periphHits [8];
  logic [3:0] modelBank;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bankedSelectDecoder i_bankedSelectDecoder (
    .clk(clk), .rstN(rstN), .addr(addr), .addrValid(addrValid),
    .rdN(rdN), .wrN(wrN), .fetchN(fetchN), .bankWe(bankWe), .bankWData(bankWData),
    .ramSelN(ramSelN), .flashSelN(flashSelN), .periphSelN(periphSelN),
    .rdMergedN(rdMergedN), .flashHiAddr(flashHiAddr)
  );

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference map by address range: {ram, flash, periph[7:0]}, active low
  function automatic logic [9:0] expSel(input int a, input bit v);
    logic [9:0] r = '1;
    if (!v) return r;
    if (a < 'h8000)      r[9] = 1'b0;
    else if (a < 'hF800) r[8] = 1'b0;
    else                 r[(a - 'hF800) / 256] = 1'b0;
    return r;
  endfunction

  function automatic string regionReq(input int a, input bit v);
    if (!v)         return "R4";
    if (a < 'h8000) return "R1";
    if (a < 'hF800) return "R2";
    return "R3";
  endfunction

  task automatic step(input int a, input bit v, input bit rd, input bit wr, input bit fe,
                      input bit we, input logic [3:0] wd);
    logic [9:0] got;
    @(negedge clk);
    addr = 16'(a); addrValid = v; rdN = rd; wrN = wr; fetchN = fe;
    bankWe = we; bankWData = wd;
    #1;
    got = {ramSelN, flashSelN, periphSelN};
    checkVal(regionReq(a, v), 32'(got), 32'(expSel(a, v)));
    checkVal("R4", 32'($countones(~got) <= 1), 32'd1);
    checkVal("R5", 32'(rdMergedN), 32'(rd & fe));
    checkVal("R8", 32'(flashHiAddr), 32'(modelBank));
    if (v && a >= 'hF800 && got[7:0] != 8'hFF) periphHits[(a - 'hF800) / 256]++;
    @(posedge clk);
    #1;
    if (we) modelBank = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (periphHits[i]) periphHits[i] = 0;
    modelBank = 4'd0;
    rstN = 1'b0; addr = '0; addrValid = 1'b0; rdN = 1'b1; wrN = 1'b1; fetchN = 1'b1;
    bankWe = 1'b0; bankWData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R7: bank register reset value
    checkVal("R7", 32'(flashHiAddr), 32'd0);
    checkVal("R4", 32'({ramSelN, flashSelN, periphSelN}), 32'h3FF);

    // Boundary addresses
    step('h7FFF, 1, 1, 1, 1, 0, 0);
    step('h8000, 1, 1, 1, 1, 0, 0);
    step('hF7FF, 1, 1, 1, 1, 0, 0);
    step('hF800, 1, 1, 1, 1, 0, 0);
    step('hFFFF, 1, 1, 1, 1, 0, 0);
    step('hF800, 0, 0, 1, 1, 0, 0);

    // R6: strobe patterns at one address leave selects unchanged
    for (int p = 0; p < 8; p++) begin
      step('hFA10, 1, p[0], p[1], p[2], 0, 0);
      checkVal("R6", 32'(periphSelN), 32'hFB);
    end

    // R8: load, then R9: write/read strobes without bankWe do not disturb it
    step('h1234, 1, 1, 1, 1, 1, 4'hA);
    step('h9000, 1, 1, 0, 1, 0, 4'h3);
    step('hFF00, 1, 0, 0, 0, 0, 4'h5);
    checkVal("R9", 32'(flashHiAddr), 32'hA);

    // Full sweep with varied strobes and bank writes every 4 KB
    foreach (periphHits[i]) periphHits[i] = 0;
    for (int a = 0; a < 65536; a++) begin
      step(a, 1, a[0], a[1], a[2], (a % 4096) == 0, 4'(a >> 12));
    end
    for (int k = 0; k < 8; k++) checkVal("R3", 32'(periphHits[k]), 32'd256);

    // R4: invalid address releases everything in each region
    step('h0100, 0, 0, 0, 0, 0, 0);
    step('hC000, 0, 0, 0, 0, 0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule